// File: doc/BRIEF.md
# Pipelined Converter Bit-Alignment and Redundancy Correction

This block sits behind the analog stages of a pipelined converter and turns their staggered raw decisions into one 10-bit result per conversion slot. Eight redundant stages each deliver a two-bit decision with the values 0, 1 or 2. A ninth stage, a single comparator, delivers one bit. A given sample reaches stage k one slot after stage k-1. For that reason, the decisions belonging to one sample arrive spread across nine consecutive slots.

Each decision from stage k enters a delay line of (9-k) slots, so every piece of one sample is present in the same slot. The aligned set is then combined by a shifted overlap-add that absorbs the redundancy. The result is registered and presented with a one-cycle strobe and a flag that marks samples carrying an illegal decision code. A slot exists only when `in_valid` is high. Delay lines advance only on such slots, so idle clocks do not disturb alignment.

Top module: `adc_corr_top`

## Requirements
- R1: When `out_valid` is high, `code` equals the sum over stages k=1..8 of D_k * 2^(9-k), plus the comparator bit. D_k is stage k's decision with 00=0, 01=1, 10=2, and stage k is carried on `stage_dec[k-1]` (stage 1 occupies bits [1:0]). The sum saturates at 1023.
- R2: The decisions combined into one result come from different slots. The comparator bit comes from the current slot. Stage k's decision comes from the accepted slot (9-k) slots earlier, so stage 1 is the oldest at 8 slots back.
- R3: A decision code of 11 counts as 10. `dec_err` is high alongside `out_valid` for every result whose aligned decisions include an 11, and is low for results without one.
- R4: Corner codes: all stages 01 with comparator 1 give mid-scale 511. All 00 with comparator 0 give 0. All 10 with comparator 1 give 1021, the highest reachable code.
- R5: After reset, `out_valid` stays low for the first 8 accepted slots. From the 9th accepted slot on, each accepted slot produces `out_valid` high for exactly the one clock that follows it.
- R6: A clock with `in_valid` low is ignored. It produces no `out_valid`, leaves `code` unchanged and does not advance alignment.
- R7: Synchronous active-high `rst` clears `code`, `out_valid` and `dec_err` to 0, empties the delay lines and restarts the 8-slot fill.
- R8: `dec_err` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the clock as a conversion slot |
| stage_dec | input | 8x2 | Stage decisions; element k-1 holds stage k |
| final_bit | input | 1 | Comparator bit of the last stage |
| code | output | 10 | Corrected result, 0 to 1023 |
| out_valid | output | 1 | One-clock strobe for a new result |
| dec_err | output | 1 | Result contained an illegal 11 decision |

## Verification
The bound checker follows the strobe on every cycle. It checks that no strobe appears before nine accepted slots, that every completing slot yields a strobe on the next clock and that an idle clock yields none. It also checks that `code` holds between strobes, that the error flag never appears without a strobe and that reset clears the outputs. The numeric result cannot be checked that way. Only the bench scenarios show that correct values come out: the queue model compares every result against the weighted sum of decisions taken from the right earlier slots, across constant patterns, a diagonal sample that only lines up when every delay is right, illegal codes, idle gaps and a reset in mid-stream.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  localparam int unsigned DEF_NUM_RES = 8;

  typedef logic [1:0] dec_t;

  localparam dec_t DEC_ZERO = 2'b00;
  localparam dec_t DEC_ONE  = 2'b01;
  localparam dec_t DEC_TWO  = 2'b10;
  localparam dec_t DEC_BAD  = 2'b11;

  // A decision code outside the three legal values
  function automatic logic dec_is_bad(dec_t d);
    return d == DEC_BAD;
  endfunction

  // Legalised decision: the unused code folds onto the top value
  function automatic dec_t dec_fix(dec_t d);
    return dec_is_bad(d) ? DEC_TWO : d;
  endfunction

endpackage

// File: rtl/corr_delay_line.sv
module corr_delay_line #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) regs[j] <= '0;
    end else if (en) begin
      regs[0] <= din;
      for (int j = 1; j < DEPTH; j++) regs[j] <= regs[j-1];
    end
  end

  assign dout = regs[DEPTH-1];

endmodule

// File: rtl/corr_fill_tracker.sv
module corr_fill_tracker #(
  parameter int unsigned FILL = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic full
);

  localparam int unsigned CW = $clog2(FILL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (en && cnt != CW'(FILL)) cnt <= cnt + 1'b1;
  end

  // Enough earlier slots seen for the current slot to complete a sample
  assign full = (cnt == CW'(FILL));

endmodule

// File: rtl/corr_merge.sv
module corr_merge
  import adc_corr_pkg::*;
#(
  parameter int unsigned NUM_RES = DEF_NUM_RES,
  parameter int unsigned CODE_W  = NUM_RES + 2
) (
  input  logic [NUM_RES-1:0][1:0] dec_al,
  input  logic                    fbit,
  output logic [CODE_W-1:0]       sum,
  output logic                    err
);

  localparam int unsigned SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] MAXC = SUM_W'((1 << CODE_W) - 1);

  // Weighted contribution of stage index i (stage i+1)
  function automatic logic [SUM_W-1:0] stage_term(dec_t d, int unsigned i);
    return SUM_W'(dec_fix(d)) << (NUM_RES - i);
  endfunction

  function automatic logic [CODE_W-1:0] clip(logic [SUM_W-1:0] v);
    return (v > MAXC) ? MAXC[CODE_W-1:0] : v[CODE_W-1:0];
  endfunction

  logic [SUM_W-1:0] acc;
  logic             bad;

  always_comb begin
    acc = SUM_W'(fbit);
    bad = 1'b0;
    for (int unsigned i = 0; i < NUM_RES; i++) begin
      acc = acc + stage_term(dec_al[i], i);
      bad = bad | dec_is_bad(dec_al[i]);
    end
  end

  assign sum = clip(acc);
  assign err = bad;

endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int unsigned NUM_RES = DEF_NUM_RES,
  parameter int unsigned CODE_W  = NUM_RES + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NUM_RES-1:0][1:0] stage_dec,
  input  logic                    final_bit,
  output logic [CODE_W-1:0]       code,
  output logic                    out_valid,
  output logic                    dec_err
);

  logic [NUM_RES-1:0][1:0] dec_al;
  logic [CODE_W-1:0]       merge_sum;
  logic                    merge_err;
  logic                    slot_full;
  logic                    slot_fire;

  // Stage g+1 waits NUM_RES-g slots; the comparator bit is not delayed
  for (genvar g = 0; g < NUM_RES; g++) begin : g_align
    corr_delay_line #(.W(2), .DEPTH(NUM_RES - g)) u_dl (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .din  (stage_dec[g]),
      .dout (dec_al[g])
    );
  end

  corr_fill_tracker #(.FILL(NUM_RES)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .en   (in_valid),
    .full (slot_full)
  );

  corr_merge #(.NUM_RES(NUM_RES), .CODE_W(CODE_W)) u_merge (
    .dec_al (dec_al),
    .fbit   (final_bit),
    .sum    (merge_sum),
    .err    (merge_err)
  );

  assign slot_fire = in_valid & slot_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      out_valid <= 1'b0;
      dec_err   <= 1'b0;
    end else begin
      out_valid <= slot_fire;
      dec_err   <= slot_fire & merge_err;
      if (slot_fire) code <= merge_sum;
    end
  end

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
  parameter int unsigned NUM_RES = 8,
  parameter int unsigned CODE_W  = NUM_RES + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              slot_fire,
  input logic [CODE_W-1:0] code,
  input logic              out_valid,
  input logic              dec_err
);

  localparam int unsigned NEED = NUM_RES + 1;
  localparam int unsigned SW   = $clog2(NEED + 1);

  logic [SW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)                            seen <= '0;
    else if (in_valid && seen != SW'(NEED)) seen <= seen + 1'b1;
  end

  a_r5_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen == SW'(NEED)));

  a_r5_fire_gives_valid: assert property (@(posedge clk) disable iff (rst)
    slot_fire |=> out_valid);

  a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r6_code_held: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(code));

  a_r8_err_with_valid: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> out_valid);

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !dec_err && code == '0));

endmodule

bind adc_corr_top adc_corr_chk #(.NUM_RES(NUM_RES), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .slot_fire (slot_fire),
  .code      (code),
  .out_valid (out_valid),
  .dec_err   (dec_err)
);

// File: tb/tb_adc_corr_top.sv
module tb_adc_corr_top;

  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [7:0][1:0] stage_dec = '0;
  logic            final_bit = 1'b0;
  logic [9:0]      code;
  logic            out_valid;
  logic            dec_err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_corr_top dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .stage_dec (stage_dec),
    .final_bit (final_bit),
    .code      (code),
    .out_valid (out_valid),
    .dec_err   (dec_err)
  );

  // Behavioural reference: history of accepted slots
  logic [15:0] qd[$];
  logic        qb[$];
  logic        exp_valid = 1'b0;
  logic        exp_err   = 1'b0;
  int          exp_code  = 0;

  always @(posedge clk) begin
    if (rst) begin
      qd.delete(); qb.delete();
      exp_valid = 1'b0; exp_err = 1'b0; exp_code = 0;
    end else if (in_valid) begin
      qd.push_back(stage_dec);
      qb.push_back(final_bit);
      if (qd.size() > 9) begin
        void'(qd.pop_front());
        void'(qb.pop_front());
      end
      if (qd.size() == 9) begin
        int s;
        logic e;
        s = int'(qb[8]);
        e = 1'b0;
        for (int k = 1; k <= 8; k++) begin
          logic [15:0] old;
          int d;
          old = qd[8 - (9 - k)];
          d = int'(old[2*(k-1) +: 2]);
          if (d == 3) begin d = 2; e = 1'b1; end
          s = s + d * (1 << (9 - k));
        end
        exp_code  = (s > 1023) ? 1023 : s;
        exp_valid = 1'b1;
        exp_err   = e;
      end else begin
        exp_valid = 1'b0; exp_err = 1'b0;
      end
    end else begin
      exp_valid = 1'b0; exp_err = 1'b0;
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    tests++;
    if (out_valid !== exp_valid) begin
      fails++;
      $display("FAIL R5/R6 out_valid got %0b exp %0b", out_valid, exp_valid);
    end
    if (code !== 10'(exp_code)) begin
      fails++;
      $display("FAIL R1/R2 code got %0d exp %0d", code, exp_code);
    end
    if (dec_err !== exp_err) begin
      fails++;
      $display("FAIL R3/R8 dec_err got %0b exp %0b", dec_err, exp_err);
    end
  end

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  // One accepted slot; returns at the negedge after its edge
  task automatic slot(logic [7:0][1:0] v, logic b);
    in_valid = 1'b1; stage_dec = v; final_bit = b;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      stage_dec = 16'($urandom); final_bit = 1'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7 reset state
    check("R7 out_valid", out_valid, 0);
    check("R7 code", code, 0);
    check("R7 dec_err", dec_err, 0);
    rst = 1'b0;

    // R5: eight slots fill with no strobe, ninth gives mid-scale (R4)
    for (int i = 0; i < 8; i++) begin
      slot({8{2'b01}}, 1'b1);
      check("R5 no strobe during fill", out_valid, 0);
    end
    slot({8{2'b01}}, 1'b1);
    check("R5 strobe on ninth slot", out_valid, 1);
    check("R4 mid-scale", code, 511);

    for (int i = 0; i < 9; i++) slot('0, 1'b0);
    check("R4 zero code", code, 0);

    for (int i = 0; i < 9; i++) slot({8{2'b10}}, 1'b1);
    check("R4 top code", code, 1021);

    // R2: a sample spread diagonally only lines up with correct delays
    for (int i = 0; i < 9; i++) slot('0, 1'b0);
    for (int m = 0; m < 9; m++) begin
      logic [7:0][1:0] v;
      v = '0;
      if (m < 8) v[m] = 2'b10;
      slot(v, m == 8);
    end
    check("R2 diagonal sample", code, 1021);

    // R3: illegal code folds to 10 and flags
    for (int i = 0; i < 9; i++) slot({8{2'b11}}, 1'b1);
    check("R3 folded code", code, 1021);
    check("R3 flag raised", dec_err, 1);
    slot({8{2'b01}}, 1'b1);
    check("R3 flag while old 11 aligned", dec_err, 1);
    for (int i = 0; i < 8; i++) slot({8{2'b01}}, 1'b1);
    check("R3 flag clears", dec_err, 0);
    check("R1 legal again", code, 511);

    // R6: idle clocks ignored
    idle(3);
    check("R6 no strobe when idle", out_valid, 0);
    check("R6 code held", code, 511);
    slot({8{2'b01}}, 1'b1);
    check("R6 alignment kept across gap", code, 511);

    // Mixed traffic with gaps and illegal codes (R1, R2, R3 via model)
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else begin
        logic [7:0][1:0] v;
        for (int k = 0; k < 8; k++)
          v[k] = ($urandom_range(0, 19) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
        slot(v, 1'($urandom));
      end
    end

    // R7: reset mid-stream restarts the fill
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 code cleared", code, 0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) slot({8{2'b10}}, 1'b0);
    check("R7 fill restarted", out_valid, 0);
    slot({8{2'b10}}, 1'b0);
    check("R7 first result after refill", code, 1020);
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule